// File: doc/BRIEF.md
# Logic Analyzer Serial Command Decoder

This block turns the byte stream from a serial receiver into commands for a logic analyzer core. A command whose first byte has its top bit clear is a short command. It is one byte long and takes effect as soon as that byte arrives. A first byte with its top bit set opens a long command. Four argument bytes follow the opcode, least significant byte first, and together they form a 32-bit value. When a long command completes, the block issues a single register write strobe. The strobe carries the opcode as the address and the assembled value as the data.

Two of the short commands drive the core. One pulses the core reset and the other pulses run. Two others ask for a reply: an identification string or a metadata record. The reply is streamed to the serial transmitter one byte at a time, with a valid/ready handshake. A host that has lost its place sends the reset byte five times in a row. That run of zeros finishes any half-collected long command and puts the decoder back at an opcode boundary.

Top module: `la_cmd_decoder`

## Requirements
- R1: After reset, tx_valid_o, reg_we_o, run_o and core_reset_o are all low, and the decoder waits for an opcode.
- R2: A received byte 0x00 taken as an opcode gives a one-cycle core_reset_o pulse in the cycle after the byte is accepted.
- R3: A received byte 0x01 taken as an opcode gives a one-cycle run_o pulse in the cycle after the byte is accepted.
- R4: An opcode with bit 7 set is followed by four argument bytes. In the cycle after the fifth byte, reg_we_o pulses for one cycle. reg_addr_o is then the opcode, and reg_data_o is the arguments, with the first argument in bits 7:0 and the last in bits 31:24. Earlier bytes cause no strobe.
- R5: For the divider opcode 0x80, reg_data_o carries only the low 24 argument bits. Bits 31:24 are zero whatever the last argument byte was.
- R6: For the flag opcode 0x82, reg_data_o carries only the low 16 argument bits. Bits 31:16 are zero.
- R7: A 0x00 byte received while a long command is open is stored as an argument. Whatever the position inside a long command, five 0x00 bytes complete it, and every zero left over is decoded as a reset. The byte after them is decoded as a fresh opcode.
- R8: Opcode 0x02 makes the transmitter send exactly the four bytes 0x31, 0x53, 0x4C, 0x4F in that order.
- R9: Opcode 0x04 sends a metadata record of tagged fields, then the terminator 0x00. The fields are: tag 0x21 with the sample memory size as 4 bytes, most significant first; tag 0x23 with the maximum sample rate as 4 bytes, most significant first; tag 0x40 with the probe count as 1 byte; tag 0x41 with the protocol version as 1 byte.
- R10: tx_data_o stays stable while tx_valid_o is high and tx_ready_i is low. A byte is consumed on a cycle where both are high.
- R11: An identify or metadata opcode that arrives while a reply is still being sent is dropped. The reply in progress goes on unchanged, and register writes still take effect.
- R12: Any other opcode with bit 7 clear causes no strobe, no pulse and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | rx_data_i holds a new byte this cycle |
| tx_ready_i | input | 1 | Transmitter can take a byte |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | tx_data_o is valid |
| reg_we_o | output | 1 | Register write strobe for a completed long command |
| reg_addr_o | output | 8 | Register address (the opcode) |
| reg_data_o | output | 32 | Register write data |
| run_o | output | 1 | Start acquisition pulse |
| core_reset_o | output | 1 | Core reset pulse |

## Verification
The bench sets a sample memory size of 0x00018000, a maximum rate of 0x05F5E100, 16 probes and protocol version 3. Every byte of the metadata record is therefore distinct from its neighbours and from its tag, so a byte that is swapped, dropped or repeated shows up in the compared reply. The argument width stays at four bytes. With that width, the realignment test can start the run of zeros at every one of the four positions inside an open long command.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_IDENT = 8'h02;
  localparam logic [7:0] OP_META  = 8'h04;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_FLAGS = 8'h82;

  typedef enum logic {REP_ID, REP_META} reply_e;
endpackage

// File: rtl/la_cmd_collector.sv
module la_cmd_collector #(
  parameter int ARG_BYTES = 4,
  localparam int DATA_W = 8 * ARG_BYTES,
  localparam int CW = $clog2(ARG_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              valid_i,
  output logic              short_v_o,
  output logic              long_v_o,
  output logic [7:0]        op_o,
  output logic [DATA_W-1:0] arg_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      short_v_o <= 1'b0;
      long_v_o  <= 1'b0;
      op_o      <= '0;
      arg_o     <= '0;
    end else begin
      short_v_o <= 1'b0;
      long_v_o  <= 1'b0;
      if (valid_i) begin
        if (cnt_q == '0) begin
          op_o <= byte_i;
          if (byte_i[7]) cnt_q <= CW'(1);
          else           short_v_o <= 1'b1;
        end else begin
          // shift right so the first argument lands in the low byte
          arg_o <= {byte_i, arg_o[DATA_W-1:8]};
          if (cnt_q == CW'(ARG_BYTES)) begin
            cnt_q    <= '0;
            long_v_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/la_cmd_dispatch.sv
module la_cmd_dispatch import la_cmd_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 24,
  parameter int FLAG_W = 16
) (
  input  logic              short_v_i,
  input  logic              long_v_i,
  input  logic [7:0]        op_i,
  input  logic [DATA_W-1:0] arg_i,
  output logic              reg_we_o,
  output logic [7:0]        reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              run_o,
  output logic              core_reset_o,
  output logic              start_id_o,
  output logic              start_meta_o
);
  localparam logic [DATA_W-1:0] DIV_MASK  = {{(DATA_W-DIV_W){1'b0}},  {DIV_W{1'b1}}};
  localparam logic [DATA_W-1:0] FLAG_MASK = {{(DATA_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}};

  logic [DATA_W-1:0] mask;

  always_comb begin
    case (op_i)
      OP_DIV:   mask = DIV_MASK;
      OP_FLAGS: mask = FLAG_MASK;
      default:  mask = '1;
    endcase
  end

  assign reg_we_o     = long_v_i;
  assign reg_addr_o   = op_i;
  assign reg_data_o   = arg_i & mask;
  assign core_reset_o = short_v_i && (op_i == OP_RESET);
  assign run_o        = short_v_i && (op_i == OP_RUN);
  assign start_id_o   = short_v_i && (op_i == OP_IDENT);
  assign start_meta_o = short_v_i && (op_i == OP_META);
endmodule

// File: rtl/la_reply_tx.sv
module la_reply_tx import la_cmd_pkg::*; #(
  parameter logic [31:0] MEM_BYTES = 32'h0000_6000,
  parameter logic [31:0] RATE_HZ   = 32'd100_000_000,
  parameter logic [7:0]  PROBES    = 8'd32,
  parameter logic [7:0]  VERSION   = 8'd2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_id_i,
  input  logic       start_meta_i,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o
);
  localparam int ID_LEN   = 4;
  localparam int META_LEN = 15;
  localparam int IW       = $clog2(META_LEN);

  logic          busy_q;
  reply_e        sel_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;

  function automatic logic [7:0] id_byte(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h31;
      2'd1:    return 8'h53;
      2'd2:    return 8'h4C;
      default: return 8'h4F;
    endcase
  endfunction

  function automatic logic [7:0] meta_byte(input logic [IW-1:0] i);
    case (int'(i))
      0:       return 8'h21;
      1:       return MEM_BYTES[31:24];
      2:       return MEM_BYTES[23:16];
      3:       return MEM_BYTES[15:8];
      4:       return MEM_BYTES[7:0];
      5:       return 8'h23;
      6:       return RATE_HZ[31:24];
      7:       return RATE_HZ[23:16];
      8:       return RATE_HZ[15:8];
      9:       return RATE_HZ[7:0];
      10:      return 8'h40;
      11:      return PROBES;
      12:      return 8'h41;
      13:      return VERSION;
      default: return 8'h00;
    endcase
  endfunction

  assign last_idx   = (sel_q == REP_ID) ? IW'(ID_LEN - 1) : IW'(META_LEN - 1);
  assign tx_valid_o = busy_q;

  always_comb begin
    if (!busy_q)              tx_data_o = 8'h00;
    else if (sel_q == REP_ID) tx_data_o = id_byte(idx_q[1:0]);
    else                      tx_data_o = meta_byte(idx_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= REP_ID;
      idx_q  <= '0;
    end else if (!busy_q) begin
      // requests are only taken while idle, so a reply is never cut
      if (start_meta_i) begin
        busy_q <= 1'b1;
        sel_q  <= REP_META;
        idx_q  <= '0;
      end else if (start_id_i) begin
        busy_q <= 1'b1;
        sel_q  <= REP_ID;
        idx_q  <= '0;
      end
    end else if (tx_ready_i) begin
      if (idx_q == last_idx) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + IW'(1);
    end
  end
endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder #(
  parameter int          ARG_BYTES = 4,
  parameter int          DIV_W     = 24,
  parameter int          FLAG_W    = 16,
  parameter logic [31:0] MEM_BYTES = 32'h0000_6000,
  parameter logic [31:0] RATE_HZ   = 32'd100_000_000,
  parameter logic [7:0]  PROBES    = 8'd32,
  parameter logic [7:0]  VERSION   = 8'd2,
  localparam int DATA_W = 8 * ARG_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              reg_we_o,
  output logic [7:0]        reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              run_o,
  output logic              core_reset_o
);
  logic              short_v, long_v, start_id, start_meta;
  logic [7:0]        op;
  logic [DATA_W-1:0] arg;

  la_cmd_collector #(.ARG_BYTES(ARG_BYTES)) u_collect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byte_i   (rx_data_i),
    .valid_i  (rx_valid_i),
    .short_v_o(short_v),
    .long_v_o (long_v),
    .op_o     (op),
    .arg_o    (arg)
  );

  la_cmd_dispatch #(.DATA_W(DATA_W), .DIV_W(DIV_W), .FLAG_W(FLAG_W)) u_dispatch (
    .short_v_i   (short_v),
    .long_v_i    (long_v),
    .op_i        (op),
    .arg_i       (arg),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_data_o  (reg_data_o),
    .run_o       (run_o),
    .core_reset_o(core_reset_o),
    .start_id_o  (start_id),
    .start_meta_o(start_meta)
  );

  la_reply_tx #(.MEM_BYTES(MEM_BYTES), .RATE_HZ(RATE_HZ), .PROBES(PROBES), .VERSION(VERSION)) u_reply (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_id_i  (start_id),
    .start_meta_i(start_meta),
    .tx_ready_i  (tx_ready_i),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o)
  );
endmodule

// File: rtl/la_cmd_decoder_chk.sv
module la_cmd_decoder_chk import la_cmd_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 24,
  parameter int FLAG_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        rx_data_i,
  input logic              rx_valid_i,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o,
  input logic              tx_valid_o,
  input logic              reg_we_o,
  input logic [7:0]        reg_addr_o,
  input logic [DATA_W-1:0] reg_data_o,
  input logic              run_o,
  input logic              core_reset_o
);
  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_div_top_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && reg_addr_o == OP_DIV |-> reg_data_o[DATA_W-1:DIV_W] == '0);

  p_flag_top_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && reg_addr_o == OP_FLAGS |-> reg_data_o[DATA_W-1:FLAG_W] == '0);

  p_we_long_op_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_addr_o[7]);

  p_pulse_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, run_o, core_reset_o}));

  p_no_pulse_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_valid_i) |-> !run_o && !core_reset_o && !reg_we_o);
endmodule

bind la_cmd_decoder la_cmd_decoder_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/la_cmd_decoder_test.sv
module la_cmd_decoder_test;
  localparam logic [31:0] T_MEM   = 32'h0001_8000;
  localparam logic [31:0] T_RATE  = 32'h05F5_E100;
  localparam logic [7:0]  T_PROBE = 8'd16;
  localparam logic [7:0]  T_VER   = 8'd3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rx_data_i = 8'h00;
  logic        rx_valid_i = 1'b0;
  logic        tx_ready_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o;
  logic        reg_we_o;
  logic [7:0]  reg_addr_o;
  logic [31:0] reg_data_o;
  logic        run_o;
  logic        core_reset_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic        s_we, s_run, s_rst;
  logic [7:0]  s_addr;
  logic [31:0] s_data;
  logic [7:0]  got [64];
  int          got_n;
  logic [7:0]  meta_exp [15];

  la_cmd_decoder #(.MEM_BYTES(T_MEM), .RATE_HZ(T_RATE), .PROBES(T_PROBE), .VERSION(T_VER)) uut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [7:0] op, input logic [31:0] a);
    if (op == 8'h80) return {8'h00, a[23:0]};
    if (op == 8'h82) return {16'h0000, a[15:0]};
    return a;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk_i);
    rx_data_i = b; rx_valid_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    s_we = reg_we_o; s_addr = reg_addr_o; s_data = reg_data_o;
    s_run = run_o; s_rst = core_reset_o;
  endtask

  task automatic send_long(input logic [7:0] op, input logic [31:0] a);
    int stray = 0;
    send_byte(op);
    stray += int'(s_we | s_run | s_rst);
    for (int i = 0; i < 3; i++) begin
      send_byte(a[8*i +: 8]);
      stray += int'(s_we | s_run | s_rst);
    end
    send_byte(a[31:24]);
    check("R4 no strobe before fifth byte", stray, 0);
    check("R4 strobe", {31'd0, s_we}, 1);
    check("R4 address", {24'd0, s_addr}, {24'd0, op});
    check("R4/R5/R6 data", s_data, exp_data(op, a));
  endtask

  // drains the reply with random ready, checking hold while stalled (R10)
  task automatic collect();
    int idle = 0;
    logic stalled = 1'b0;
    logic [7:0] held = 8'h00;
    got_n = 0;
    while (idle < 6) begin
      @(negedge clk_i);
      tx_ready_i = ($urandom % 3) != 0;
      if (tx_valid_o) begin
        idle = 0;
        if (stalled) check("R10 hold while stalled", {24'd0, tx_data_o}, {24'd0, held});
        if (tx_ready_i) begin
          if (got_n < 64) got[got_n] = tx_data_o;
          got_n++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          held = tx_data_o;
        end
      end else begin
        idle++;
      end
    end
    tx_ready_i = 1'b0;
  endtask

  task automatic check_id(input string req);
    logic [7:0] idb [4];
    int errs = 0;
    idb = '{8'h31, 8'h53, 8'h4C, 8'h4F};
    check({req, " length"}, got_n, 4);
    for (int i = 0; i < 4 && i < got_n; i++) if (got[i] !== idb[i]) errs++;
    check({req, " bytes"}, errs, 0);
  endtask

  initial begin
    int resets, writes, errs;
    logic [7:0] op;
    logic [31:0] a;
    void'($urandom(32'd20240611));
    meta_exp[0] = 8'h21;
    for (int i = 0; i < 4; i++) meta_exp[1 + i] = T_MEM[31 - 8*i -: 8];
    meta_exp[5] = 8'h23;
    for (int i = 0; i < 4; i++) meta_exp[6 + i] = T_RATE[31 - 8*i -: 8];
    meta_exp[10] = 8'h40; meta_exp[11] = T_PROBE;
    meta_exp[12] = 8'h41; meta_exp[13] = T_VER;
    meta_exp[14] = 8'h00;

    repeat (3) @(negedge clk_i);
    check("R1 outputs idle in reset", {28'd0, tx_valid_o, reg_we_o, run_o, core_reset_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 outputs idle after reset", {28'd0, tx_valid_o, reg_we_o, run_o, core_reset_o}, 0);

    send_byte(8'h00);
    check("R2 reset pulse", {29'd0, s_rst, s_run, s_we}, 32'h4);
    @(negedge clk_i);
    check("R2 pulse one cycle", {31'd0, core_reset_o}, 0);
    send_byte(8'h01);
    check("R3 run pulse", {29'd0, s_rst, s_run, s_we}, 32'h2);
    @(negedge clk_i);
    check("R3 pulse one cycle", {31'd0, run_o}, 0);

    send_byte(8'h03);
    check("R12 opcode 0x03 silent", {29'd0, s_rst, s_run, s_we}, 0);
    send_byte(8'h7F);
    check("R12 opcode 0x7F silent", {29'd0, s_rst, s_run, s_we}, 0);
    collect();
    check("R12 no reply", got_n, 0);

    send_long(8'h80, 32'hFFFF_FFFF);   // R5
    send_long(8'h82, 32'hFFFF_FFFF);   // R6
    send_long(8'h81, 32'h0000_0000);   // R7 zeros stored as arguments
    check("R7 zero args no reset", {31'd0, s_rst}, 0);

    for (int n = 0; n < 40; n++) begin
      op = 8'h80 | 8'($urandom % 128);
      a = $urandom;
      send_long(op, a);                // R4
    end

    // R7: start the zero run at every position inside a long command
    for (int k = 1; k <= 4; k++) begin
      send_byte(8'h85);
      for (int j = 1; j < k; j++) send_byte(8'h10 + 8'(j));
      resets = 0; writes = 0;
      for (int z = 0; z < 5; z++) begin
        send_byte(8'h00);
        resets += int'(s_rst);
        writes += int'(s_we);
      end
      check("R7 leftover zeros are resets", resets, k);
      check("R7 pending command completes once", writes, 1);
      send_byte(8'h01);
      check("R7 realigned to opcode", {31'd0, s_run}, 1);
    end

    send_byte(8'h02);
    collect();
    check_id("R8 identify");

    send_byte(8'h04);
    collect();
    check("R9 metadata length", got_n, 15);
    errs = 0;
    for (int i = 0; i < 15 && i < got_n; i++) if (got[i] !== meta_exp[i]) errs++;
    check("R9 metadata bytes", errs, 0);

    // R11: requests during a stalled reply are dropped, writes still work
    send_byte(8'h02);
    send_byte(8'h04);
    send_byte(8'h02);
    send_long(8'h82, 32'h1234_ABCD);
    send_byte(8'h00);
    check("R11 reset during reply", {31'd0, s_rst}, 1);
    collect();
    check_id("R11 reply unchanged");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule